// File: doc/BRIEF.md
# Cascaded Serial Bit-Rate Enable Generator

This block produces the bit-rate enable for a serial port. It does so with a chain of dividers that all run on the oscillator clock. A gear prescaler turns the oscillator into an instruction-cycle tick. A source selector then picks one of three things: that tick, that tick divided by 16 or 64, or the rising edges of an external timer tick.

The selected source feeds a compare-match counter that divides by the programmed compare value plus one. A toggle stage halves that rate. A last divider, chosen by the transfer mode, turns the result into a single-cycle enable pulse for the serial shifter.

Every stage is a clock-enable pulse, so the block creates no derived clocks. When the compare value, the source select, the ratio bit or the mode bit changes, the whole chain restarts. This lets the first period after a reconfiguration start from a known phase. The bit period in oscillator cycles is gear × source × (compare + 1) × 2 × final divider.

Top module: `baud_clock_gen`

## Requirements
- R1: `gearSel` sets the instruction-cycle period in oscillator cycles: code 00 gives 64, 01 gives 16, 10 gives 8 and 11 gives 4.
- R2: `srcSel` picks the compare-stage source: 00 is every instruction cycle, 01 is every 16th, 10 is every 64th, and 11 is each rising edge of `extTick`.
- R3: The compare stage divides its source by `cmpVal` + 1, for any 8-bit value from 0 to 255.
- R4: The compare-match output toggles, so it adds a fixed divide by 2 after the compare stage.
- R5: With `syncMode` = 0 (asynchronous), the final divider is 16 when `ratioSel` = 0 and 64 when `ratioSel` = 1.
- R6: With `syncMode` = 1 (synchronous), the final divider is 2 whatever the value of `ratioSel`.
- R7: `baudEn` is high for exactly one oscillator cycle per period. Consecutive pulses are spaced gear × source × (cmpVal+1) × 2 × final oscillator cycles apart.
- R8: A change of `cmpVal`, `srcSel`, `ratioSel` or `syncMode` clears every divider and any pending pulse on the next clock edge. With an internal source, `baudEn` is then first seen high P clock edges after that clearing edge, where P is the new period.
- R9: `baudEn` stays low for as long as `rstN` is low.
- R10: `extTick` passes through a two-stage synchronizer and a rising-edge detector. Each low-to-high transition counts exactly once, however long the high phase lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gearSel | input | 2 | Instruction-cycle gear select |
| srcSel | input | 2 | Compare-stage source select |
| cmpVal | input | 8 | Compare value; the stage divides by this value plus one |
| ratioSel | input | 1 | Asynchronous final ratio: 0 gives 16, 1 gives 64 |
| syncMode | input | 1 | 1 selects synchronous transfer (final divide by 2) |
| extTick | input | 1 | External timer tick, asynchronous to clk |
| baudEn | output | 1 | One-cycle bit-rate enable pulse |

## Verification
The hardest condition to reach from the ports is an exact, known phase relation between a reconfiguration and the first pulse that follows it. If the new settings happen to match the old ones, no restart happens, and the latency measured depends on history. The stimulus therefore always moves the compare value to a neighbouring value for one cycle before it applies the target setting. This guarantees that a restart occurs, so the first-pulse latency of P+1 sampled cycles can be checked.

Random settings are drawn under a bound on the predicted period, which keeps the slowest source and gear combinations inside the run length. Directed cases cover compare value 255, the largest source divide, and an external tick with both narrow and wide high phases.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef struct packed {
    logic restart;
    logic srcTick;
  } chainStrobeT;

  function automatic logic [6:0] gearLimit(input logic [1:0] code);
    case (code)
      2'b00:   return 7'd63;
      2'b01:   return 7'd15;
      2'b10:   return 7'd7;
      default: return 7'd3;
    endcase
  endfunction

  function automatic logic [5:0] srcLimit(input logic [1:0] code);
    case (code)
      2'b01:   return 6'd15;
      2'b10:   return 6'd63;
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic [5:0] finalLimit(input logic ratio, input logic syncM);
    if (syncM)      return 6'd1;
    else if (ratio) return 6'd63;
    else            return 6'd15;
  endfunction

endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
#(
  parameter int CMP_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       gearSel,
  input  logic [1:0]       srcSel,
  input  logic [CMP_W-1:0] cmpVal,
  input  logic             ratioSel,
  input  logic             syncMode,
  input  logic             extTick,
  output chainStrobeT      strobe
);

  localparam int GEAR_W = 7;
  localparam int SRC_W  = 6;
  localparam logic [1:0] SRC_EXT = 2'b11;

  // configuration snapshot for restart detection
  logic [CMP_W-1:0] cmpQ;
  logic [1:0]       srcQ;
  logic             ratioQ;
  logic             modeQ;
  logic             restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpQ   <= '0;
      srcQ   <= '0;
      ratioQ <= 1'b0;
      modeQ  <= 1'b0;
    end else begin
      cmpQ   <= cmpVal;
      srcQ   <= srcSel;
      ratioQ <= ratioSel;
      modeQ  <= syncMode;
    end
  end

  assign restart = (cmpVal != cmpQ) || (srcSel != srcQ) ||
                   (ratioSel != ratioQ) || (syncMode != modeQ);

  // gear prescaler -> instruction-cycle tick
  logic [GEAR_W-1:0] gearCnt;
  logic              instTick;

  assign instTick = (gearCnt >= gearLimit(gearSel));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          gearCnt <= '0;
    else if (restart)   gearCnt <= '0;
    else if (instTick)  gearCnt <= '0;
    else                gearCnt <= gearCnt + 1'b1;
  end

  // source prescaler on instruction ticks
  logic [SRC_W-1:0] srcCnt;
  logic             srcWrap;
  logic             intTick;

  assign srcWrap = (srcCnt >= srcLimit(srcSel));
  assign intTick = instTick && srcWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             srcCnt <= '0;
    else if (restart)      srcCnt <= '0;
    else if (instTick)     srcCnt <= srcWrap ? '0 : srcCnt + 1'b1;
  end

  // external tick synchronizer and rising-edge detect
  logic [SYNC_STAGES-1:0] extSync;
  logic                   extPrev;
  logic                   extRise;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) extSync[0] <= 1'b0;
          else       extSync[0] <= extTick;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) extSync[i] <= 1'b0;
          else       extSync[i] <= extSync[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extSync[SYNC_STAGES-1];
  end

  assign extRise = extSync[SYNC_STAGES-1] && !extPrev;

  assign strobe.restart = restart;
  assign strobe.srcTick = (srcSel == SRC_EXT) ? extRise : intTick;

endmodule

// File: rtl/baud_datapath.sv
module baud_datapath
  import baud_pkg::*;
#(
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  chainStrobeT      strobe,
  input  logic [CMP_W-1:0] cmpVal,
  input  logic             ratioSel,
  input  logic             syncMode,
  output logic             baudEn
);

  localparam int FIN_W = 6;

  // compare-match counter
  logic [CMP_W-1:0] cmpCnt;
  logic             match;

  assign match = strobe.srcTick && (cmpCnt >= cmpVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cmpCnt <= '0;
    else if (strobe.restart)  cmpCnt <= '0;
    else if (strobe.srcTick)  cmpCnt <= match ? '0 : cmpCnt + 1'b1;
  end

  // toggle stage: one half-tick per two matches
  logic toggleQ;
  logic halfTick;

  assign halfTick = match && toggleQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               toggleQ <= 1'b0;
    else if (strobe.restart) toggleQ <= 1'b0;
    else if (match)          toggleQ <= !toggleQ;
  end

  // mode-dependent final divider
  logic [FIN_W-1:0] finCnt;
  logic             finWrap;

  assign finWrap = (finCnt >= finalLimit(ratioSel, syncMode));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               finCnt <= '0;
    else if (strobe.restart) finCnt <= '0;
    else if (halfTick)       finCnt <= finWrap ? '0 : finCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               baudEn <= 1'b0;
    else if (strobe.restart) baudEn <= 1'b0;
    else                     baudEn <= halfTick && finWrap;
  end

endmodule

// File: rtl/baud_clock_gen.sv
module baud_clock_gen
  import baud_pkg::*;
#(
  parameter int CMP_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       gearSel,
  input  logic [1:0]       srcSel,
  input  logic [CMP_W-1:0] cmpVal,
  input  logic             ratioSel,
  input  logic             syncMode,
  input  logic             extTick,
  output logic             baudEn
);

  chainStrobeT strobe;

  baud_ctrl #(.CMP_W(CMP_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .gearSel  (gearSel),
    .srcSel   (srcSel),
    .cmpVal   (cmpVal),
    .ratioSel (ratioSel),
    .syncMode (syncMode),
    .extTick  (extTick),
    .strobe   (strobe)
  );

  baud_datapath #(.CMP_W(CMP_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmpVal   (cmpVal),
    .ratioSel (ratioSel),
    .syncMode (syncMode),
    .baudEn   (baudEn)
  );

endmodule

// File: rtl/baud_checker.sv
module baud_checker #(
  parameter int CMP_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       gearSel,
  input logic [1:0]       srcSel,
  input logic [CMP_W-1:0] cmpVal,
  input logic             ratioSel,
  input logic             syncMode,
  input logic             baudEn
);

  logic [CMP_W-1:0] cmpQ;
  logic [1:0]       gearQ, srcQ;
  logic             ratioQ, modeQ;

  always_ff @(posedge clk) begin
    cmpQ   <= cmpVal;
    gearQ  <= gearSel;
    srcQ   <= srcSel;
    ratioQ <= ratioSel;
    modeQ  <= syncMode;
  end

  logic chainChange, anyChange;
  assign chainChange = (cmpVal != cmpQ) || (srcSel != srcQ) ||
                       (ratioSel != ratioQ) || (syncMode != modeQ);
  assign anyChange   = chainChange || (gearSel != gearQ);

  function automatic logic [31:0] periodOf(input logic [1:0] g, input logic [1:0] s,
                                           input logic [CMP_W-1:0] c, input logic r,
                                           input logic m);
    logic [31:0] gm, sm, fm;
    gm = (g == 2'd0) ? 32'd64 : (g == 2'd1) ? 32'd16 : (g == 2'd2) ? 32'd8 : 32'd4;
    sm = (s == 2'd1) ? 32'd16 : (s == 2'd2) ? 32'd64 : 32'd1;
    fm = m ? 32'd2 : (r ? 32'd64 : 32'd16);
    return gm * sm * (32'(c) + 32'd1) * 32'd2 * fm;
  endfunction

  // cycles since the previous pulse, valid only when nothing changed in between
  logic [31:0] gap;
  logic        clean;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap   <= '0;
      clean <= 1'b0;
    end else if (anyChange) begin
      gap   <= '0;
      clean <= 1'b0;
    end else if (baudEn) begin
      gap   <= 32'd1;
      clean <= (srcSel != 2'b11);
    end else begin
      gap   <= gap + 32'd1;
    end
  end

  p_async_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (baudEn && clean && !anyChange && !syncMode) |->
      (gap == periodOf(gearSel, srcSel, cmpVal, ratioSel, syncMode)));

  p_sync_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (baudEn && clean && !anyChange && syncMode) |->
      (gap == periodOf(gearSel, srcSel, cmpVal, ratioSel, syncMode)));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    baudEn |=> !baudEn);

  p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    chainChange |=> !baudEn);

endmodule

bind baud_clock_gen baud_checker #(.CMP_W(CMP_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .gearSel  (gearSel),
  .srcSel   (srcSel),
  .cmpVal   (cmpVal),
  .ratioSel (ratioSel),
  .syncMode (syncMode),
  .baudEn   (baudEn)
);

// File: tb/tb_baud_clock_gen.sv
`timescale 1ns/1ps
module tb_baud_clock_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] gearSel = 2'b11;
  logic [1:0] srcSel = 2'b00;
  logic [7:0] cmpVal = 8'd0;
  logic       ratioSel = 1'b0;
  logic       syncMode = 1'b0;
  logic       extTick = 1'b0;
  logic       baudEn;

  int vectors = 0;
  int fails = 0;

  logic extOn = 1'b0;
  int   extPer = 6;
  int   extHigh = 1;

  always #5 clk = ~clk;

  baud_clock_gen dut (
    .clk(clk), .rstN(rstN), .gearSel(gearSel), .srcSel(srcSel), .cmpVal(cmpVal),
    .ratioSel(ratioSel), .syncMode(syncMode), .extTick(extTick), .baudEn(baudEn)
  );

  // external tick driver
  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      if (extOn) begin
        phase++;
        extTick = ((phase % extPer) < extHigh);
      end else begin
        phase = 0;
        extTick = 1'b0;
      end
    end
  end

  function automatic int expPeriod(int g, int s, int c, int r, int m);
    int gm, sm, fm;
    gm = (g == 0) ? 64 : (g == 1) ? 16 : (g == 2) ? 8 : 4;
    sm = (s == 1) ? 16 : (s == 2) ? 64 : 1;
    fm = (m != 0) ? 2 : ((r != 0) ? 64 : 16);
    return gm * sm * (c + 1) * 2 * fm;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // apply settings; a one-cycle compare nudge guarantees a restart
  task automatic applyCfg(int g, int s, int c, int r, int m);
    @(negedge clk);
    cmpVal = 8'(c) ^ 8'd1;
    @(negedge clk);
    gearSel = 2'(g); srcSel = 2'(s); cmpVal = 8'(c);
    ratioSel = 1'(r); syncMode = 1'(m);
  endtask

  task automatic waitPulse(output int n, input int limit);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (baudEn) begin
        n = i;
        break;
      end
    end
  endtask

  // measures latency from restart and spacing to the following pulse
  task automatic runCfg(int g, int s, int c, int r, int m, string req);
    int p, lat, sp;
    p = expPeriod(g, s, c, r, m);
    applyCfg(g, s, c, r, m);
    waitPulse(lat, p + 10);
    check(lat == p + 1, {req, "/R8 first pulse latency"}, lat, p + 1);
    @(negedge clk);
    check(baudEn == 1'b0, "R7 pulse width", int'(baudEn), 0);
    waitPulse(sp, p + 10);
    check(sp + 1 == p, {req, "/R7 pulse spacing"}, sp + 1, p);
  endtask

  task automatic runExt(int c, int r, int m, int per, int hi, string req);
    int p, n, sp;
    p = per * (c + 1) * 2 * ((m != 0) ? 2 : ((r != 0) ? 64 : 16));
    extPer = per; extHigh = hi;
    applyCfg(3, 3, c, r, m);
    extOn = 1'b1;
    waitPulse(n, 2 * p + 20);
    waitPulse(sp, p + 10);
    check(sp == p, req, sp, p);
    extOn = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd5150));
    // R9: idle during reset
    begin
      int highs = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (baudEn) highs++;
      end
      check(highs == 0, "R9 idle in reset", highs, 0);
    end
    rstN = 1'b1;

    // R1 each gear code
    runCfg(3, 0, 0, 0, 0, "R1 gear 11");
    runCfg(2, 0, 0, 0, 0, "R1 gear 10");
    runCfg(1, 0, 0, 0, 0, "R1 gear 01");
    runCfg(0, 0, 0, 0, 0, "R1 gear 00");
    // R2 source divides
    runCfg(3, 1, 0, 0, 0, "R2 src 01");
    runCfg(3, 2, 0, 0, 0, "R2 src 10");
    // R3 / R4 compare and toggle
    runCfg(3, 0, 1, 0, 0, "R3 cmp 1");
    runCfg(3, 0, 255, 0, 1, "R3 cmp 255");
    runCfg(2, 0, 2, 0, 1, "R4 toggle halves");
    // R5 ratio
    runCfg(3, 0, 0, 1, 0, "R5 ratio 64");
    // R6 sync ignores ratio
    runCfg(3, 0, 0, 0, 1, "R6 sync ratio0");
    runCfg(3, 0, 0, 1, 1, "R6 sync ratio1");
    // R10 external tick, narrow and wide high phases
    runExt(2, 0, 1, 6, 1, "R10 ext narrow");
    runExt(2, 0, 1, 6, 5, "R10 ext wide");
    runExt(0, 1, 0, 4, 2, "R2 ext source");

    // random settings bounded in period
    for (int k = 0; k < 16; k++) begin
      int g, s, c, r, m;
      do begin
        g = int'($urandom % 4);
        s = int'($urandom % 3);
        c = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 4);
        r = int'($urandom % 2);
        m = int'($urandom % 2);
      end while (expPeriod(g, s, c, r, m) > 2500);
      runCfg(g, s, c, r, m, "R7 random");
    end

    // R9: reset mid-run keeps output quiet
    applyCfg(3, 0, 0, 0, 1);
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    begin
      int highs = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (baudEn) highs++;
      end
      check(highs == 0, "R9 idle in mid-run reset", highs, 0);
    end
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule